// File: doc/BRIEF.md
# UART Multiprocessor Address Filter

This block sits behind the receive shifter of a serial port that runs in multiprocessor mode, where every frame carries a ninth bit marking it as an address frame (1) or a data frame (0). For each completed frame it decides whether the local node should take the frame and raise its receive interrupt. Address frames are compared against two software-written 8-bit registers: a node address and an address mask. A frame is taken when it matches either the masked node address or the group (broadcast) address, which is formed from the same two registers.

A mask bit of 1 makes the matching address bit significant. A mask bit of 0 makes it a don't-care. The broadcast address is the bitwise OR of the address and the mask, and each zero bit of that OR is a don't-care. With this scheme one byte can select a chosen subset of nodes. For example, several nodes can share the upper bits of their address and differ only in which low bit is significant. When an address frame matches, the node stays selected and takes the data frames that follow. When an address frame misses, the node drops out and ignores data until the next matching address. Both registers clear on reset, so every address matches and the filter is transparent until software programs it.

The shifter and the baud generator are outside the block. They appear only as a one-cycle receive strobe carrying a byte and a ninth bit.

Top module: `mp_addr_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, `addrMatch` and `rxIrq` are 0, and the address and mask registers hold 0.
- R2: A cycle with `regWrEn`=1 writes `regWrData` into the address register when `regWrSel`=0, or into the mask register when `regWrSel`=1. The new value applies to receive strobes from the next cycle on.
- R3: A received byte hits the node address when, for every bit position whose mask bit is 1, the byte bit equals the address bit. Positions whose mask bit is 0 are ignored.
- R4: A received byte hits the broadcast address when it has a 1 in every position where (address OR mask) is 1. Positions where that OR is 0 are ignored.
- R5: With `mpModeEn`=1, a strobe with `rxBit9`=1 sets `addrMatch` in the next cycle to whether the byte hits R3 or R4. In the same cycle, `rxIrq` pulses exactly when that hit is true.
- R6: With `mpModeEn`=1, a strobe with `rxBit9`=0 pulses `rxIrq` in the next cycle only if `addrMatch` is 1 at the strobe, and it leaves `addrMatch` unchanged.
- R7: With `mpModeEn`=0, every strobe pulses `rxIrq` in the next cycle whatever its ninth bit and byte, and `addrMatch` stays unchanged.
- R8: With both registers at 0, every address frame hits, so every address frame raises `rxIrq`.
- R9: `rxIrq` is high for one cycle and only in the cycle after a receive strobe. `addrMatch` is 0 after reset until the first matching address frame.
- R10: Address 8'b1110_0000 with mask 8'b1111_1001 or 8'b1111_1010 accepts byte 8'b1110_0100. With mask 8'b1111_1100 the same byte is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write enable |
| regWrSel | input | 1 | Write target: 0 address, 1 mask |
| regWrData | input | DATA_W | Register write data |
| mpModeEn | input | 1 | Multiprocessor filtering enable |
| rxStrobe | input | 1 | One-cycle receive-complete strobe |
| rxData | input | DATA_W | Received byte |
| rxBit9 | input | 1 | Received ninth bit (1 = address frame) |
| addrMatch | output | 1 | Node currently selected by an address frame |
| rxIrq | output | 1 | Receive interrupt request pulse |

## Verification
The bench builds the block with the default `DATA_W` of 8, which is the width the group-addressing examples are stated in. At this width the three nodes from those examples and the all-ones broadcast byte can be reproduced exactly, bit for bit. Eight bits is also narrow enough that a run of random register values and random bytes lands often on both hits and misses, in both modes, for both kinds of frame.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

  // Register-load strobes issued by control to the datapath
  typedef struct packed {
    logic loadAddr;
    logic loadMask;
  } mpfStrobes_t;

endpackage

// File: rtl/mpf_mask_cmp.sv
module mpf_mask_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] pattern,
  input  logic [W-1:0] care,
  output logic         hit
);

  // Hit when every cared-for bit of value equals pattern
  logic [W-1:0] diffBits;

  always_comb begin
    diffBits = (value ^ pattern) & care;
    hit      = (diffBits == '0);
  end

endmodule

// File: rtl/mpf_datapath.sv
module mpf_datapath
  import mpf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mpfStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rxData,
  output logic              givenHit,
  output logic              bcastHit
);

  logic [DATA_W-1:0] addrReg;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] bcastPat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrReg <= '0;
      maskReg <= '0;
    end else begin
      if (strobes.loadAddr) addrReg <= wrData;
      if (strobes.loadMask) maskReg <= wrData;
    end
  end

  always_comb bcastPat = addrReg | maskReg;

  mpf_mask_cmp #(.W(DATA_W)) i_givenCmp (
    .value  (rxData),
    .pattern(addrReg),
    .care   (maskReg),
    .hit    (givenHit)
  );

  // Broadcast: ones required wherever the OR is one
  mpf_mask_cmp #(.W(DATA_W)) i_bcastCmp (
    .value  (rxData),
    .pattern(bcastPat),
    .care   (bcastPat),
    .hit    (bcastHit)
  );

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadAddr |=> addrReg == $past(wrData));

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadMask |=> maskReg == $past(wrData));

  p_open_when_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addrReg == '0 && maskReg == '0) |-> (givenHit && bcastHit));

endmodule

// File: rtl/mpf_control.sv
module mpf_control
  import mpf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic        regWrSel,
  input  logic        mpModeEn,
  input  logic        rxStrobe,
  input  logic        rxBit9,
  input  logic        givenHit,
  input  logic        bcastHit,
  output mpfStrobes_t strobes,
  output logic        addrMatch,
  output logic        rxIrq
);

  logic frameHit;
  logic isAddrFrame;
  logic takeFrame;

  always_comb begin
    strobes.loadAddr = regWrEn & ~regWrSel;
    strobes.loadMask = regWrEn &  regWrSel;
    frameHit    = givenHit | bcastHit;
    isAddrFrame = mpModeEn & rxBit9;
    if (!mpModeEn)        takeFrame = 1'b1;
    else if (rxBit9)      takeFrame = frameHit;
    else                  takeFrame = addrMatch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrMatch <= 1'b0;
      rxIrq     <= 1'b0;
    end else begin
      rxIrq <= rxStrobe & takeFrame;
      if (rxStrobe && isAddrFrame) addrMatch <= frameHit;
    end
  end

  p_irq_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrq |-> $past(rxStrobe));

  p_plain_mode_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rxStrobe && !mpModeEn) |=> (rxIrq && $stable(addrMatch)));

  p_data_keeps_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rxStrobe && mpModeEn && !rxBit9) |=> $stable(addrMatch));

  p_addr_irq_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rxStrobe && mpModeEn && rxBit9) |=> (rxIrq == addrMatch));

endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
  import mpf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              mpModeEn,
  input  logic              rxStrobe,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxBit9,
  output logic              addrMatch,
  output logic              rxIrq
);

  mpfStrobes_t strobes;
  logic        givenHit;
  logic        bcastHit;

  mpf_control i_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .regWrEn  (regWrEn),
    .regWrSel (regWrSel),
    .mpModeEn (mpModeEn),
    .rxStrobe (rxStrobe),
    .rxBit9   (rxBit9),
    .givenHit (givenHit),
    .bcastHit (bcastHit),
    .strobes  (strobes),
    .addrMatch(addrMatch),
    .rxIrq    (rxIrq)
  );

  mpf_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .wrData  (regWrData),
    .rxData  (rxData),
    .givenHit(givenHit),
    .bcastHit(bcastHit)
  );

endmodule

// File: tb/test_mp_addr_filter.sv
`timescale 1ns/1ps
module test_mp_addr_filter;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         regWrEn = 1'b0;
  logic         regWrSel = 1'b0;
  logic [W-1:0] regWrData = '0;
  logic         mpModeEn = 1'b0;
  logic         rxStrobe = 1'b0;
  logic [W-1:0] rxData = '0;
  logic         rxBit9 = 1'b0;
  logic         addrMatch;
  logic         rxIrq;

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mp_addr_filter #(.DATA_W(W)) i_mp_addr_filter (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .mpModeEn(mpModeEn), .rxStrobe(rxStrobe),
    .rxData(rxData), .rxBit9(rxBit9), .addrMatch(addrMatch), .rxIrq(rxIrq)
  );

  // Behavioural reference model
  int mAddr = 0, mMask = 0;
  bit mSel = 0, mIrq = 0;

  function automatic bit hitFn(int b, int a, int m);
    int g;
    bit given = 1, bc = 1;
    g = a | m;
    for (int i = 0; i < W; i++) begin
      if (m[i] && (b[i] != a[i])) given = 0;
      if (g[i] && !b[i]) bc = 0;
    end
    return given || bc;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mAddr <= 0; mMask <= 0; mSel <= 0; mIrq <= 0;
    end else begin
      bit h;
      h = hitFn(int'(rxData), mAddr, mMask);
      if (regWrEn && !regWrSel) mAddr <= int'(regWrData);
      if (regWrEn &&  regWrSel) mMask <= int'(regWrData);
      mIrq <= 0;
      if (rxStrobe) begin
        if (!mpModeEn) mIrq <= 1;
        else if (rxBit9) begin mIrq <= h; mSel <= h; end
        else mIrq <= mSel;
      end
    end
  end

  always begin
    @(posedge clk);
    #1;
    if (!done) begin
      checks++;
      if (addrMatch !== mSel) begin
        fails++;
        $display("FAIL %s addrMatch actual %b expected %b", tag, addrMatch, mSel);
      end
      checks++;
      if (rxIrq !== mIrq) begin
        fails++;
        $display("FAIL %s rxIrq actual %b expected %b", tag, rxIrq, mIrq);
      end
    end
  end

  task automatic wrReg(bit sel, logic [W-1:0] v, string t);
    @(negedge clk);
    tag = t; regWrEn = 1; regWrSel = sel; regWrData = v;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic frame(logic [W-1:0] b, bit nine, bit mp, string t);
    @(negedge clk);
    tag = t; mpModeEn = mp; rxStrobe = 1; rxData = b; rxBit9 = nine;
    @(negedge clk);
    rxStrobe = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8: cleared registers accept any address
    frame(8'h5A, 1, 1, "R8");
    frame(8'h00, 0, 1, "R6");
    // R2/R3: program the first example node
    wrReg(0, 8'hE0, "R2");
    wrReg(1, 8'hF9, "R2");
    frame(8'hE6, 1, 1, "R3");
    frame(8'h33, 0, 1, "R6");
    frame(8'hE5, 1, 1, "R3");
    frame(8'h44, 0, 1, "R6");
    frame(8'hE4, 1, 1, "R10");
    frame(8'hFF, 1, 1, "R4");
    wrReg(1, 8'hFA, "R2");
    frame(8'hE4, 1, 1, "R10");
    wrReg(1, 8'hFC, "R2");
    frame(8'hE4, 1, 1, "R10");
    frame(8'h12, 0, 1, "R6");
    frame(8'hFD, 1, 1, "R4");
    // R7: filter disabled, ninth bit irrelevant
    frame(8'h01, 1, 0, "R7");
    frame(8'h02, 0, 0, "R7");
    frame(8'h00, 1, 1, "R5");
    frame(8'h03, 1, 0, "R7");
    // R9: idle cycles hold no interrupt
    repeat (3) @(negedge clk);
    tag = "R9";
    repeat (3) @(negedge clk);
    // Random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k == 0) wrReg(1'($urandom_range(0, 1)), 8'($urandom), "R2");
      else frame(8'($urandom), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 4) != 0), "R5");
    end
    // Reset mid-run
    @(negedge clk);
    tag = "R1"; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    frame(8'h77, 0, 1, "R9");
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule